// File: doc/BRIEF.md
# Serial Display Command/Data Writer

This block sends bytes to a display controller over a write-only, four-wire serial link. The four lines are an active-low chip select, a command/data select line, a serial clock and a serial data line. A host starts a request with a one-cycle pulse and a 2-bit request type. There are three request types: one command byte, a command byte followed by one data byte, or a burst of data bytes. The command byte comes from a parallel input. Data bytes come from a byte-wide valid/ready stream.

Each byte goes out most significant bit first, as eight serial clock pulses. The serial data line is set while the clock is low, and the display samples it on the rising edge. The command/data select line is held through the whole byte, so it is correct at the eighth rising edge, where the display captures it: low for a command byte, high for a data byte. Every half period of the serial clock lasts `div_ratio + 1` system clock cycles. The divider value is taken when the request is accepted. Chip select stays low from the first byte to the last. When the request ends, all four lines return to their high idle levels before `busy` falls.

Top module: `serdisp_writer`

## Requirements
- R1: After reset, and whenever `busy` is low, `lcd_csn`, `lcd_dc`, `lcd_sclk` and `lcd_sdo` are all high, and `in_ready` is low.
- R2: A request of type 2'b00 sends `cmd_byte` as eight rising `lcd_sclk` edges, MSB first, with `lcd_csn` low and `lcd_dc` low on every edge.
- R3: `lcd_sdo` changes only while `lcd_sclk` is low. It is held unchanged through every high phase of the clock while `lcd_csn` is low.
- R4: Every low phase of `lcd_sclk`, and every high phase inside a byte, lasts exactly `div_ratio + 1` system clock cycles. `div_ratio` is sampled with the start pulse.
- R5: A request of type 2'b01 sends `cmd_byte` with `lcd_dc` low. It then sends one byte taken from the stream with `lcd_dc` high. `lcd_csn` stays low between the two bytes.
- R6: A request of type 2'b10 with a nonzero `burst_len` sends exactly `burst_len` bytes, taken from the stream in order, each with `lcd_dc` high. `lcd_csn` makes a single low period that covers the whole burst.
- R7: At the end of a transfer, all four lines are driven high for at least one cycle while `busy` is still high. `busy` falls after that.
- R8: A burst request with `burst_len` of zero produces no `lcd_sclk` edge and leaves `lcd_csn` high. `busy` is high for exactly one cycle.
- R9: A start pulse that arrives while `busy` is high is ignored. It changes neither the bytes sent nor their timing, and no second transfer follows.
- R10: `in_ready` is high only while the block waits for a stream byte. A byte is consumed only when `in_valid` and `in_ready` are both high. While the stream stalls, `lcd_csn` stays low and `lcd_sclk` stays high.
- R11: Request type 2'b11 is reserved. It behaves like an empty burst: no clock edges, `lcd_csn` stays high, and `busy` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| req_kind | input | 2 | Request type: 00 command, 01 command+data, 10 burst, 11 reserved |
| cmd_byte | input | 8 | Command byte for types 00 and 01 |
| burst_len | input | LEN_W | Number of data bytes for type 10 |
| div_ratio | input | DIV_W | Half period of the serial clock, minus one, in system cycles |
| in_data | input | 8 | Stream data byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block accepts a stream byte |
| busy | output | 1 | A request is in progress |
| lcd_csn | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | Command/data select: 0 command, 1 data |
| lcd_sclk | output | 1 | Serial clock |
| lcd_sdo | output | 1 | Serial data |

## Verification
The bench decodes the serial lines on every rising clock edge. It rebuilds each byte and records the select level at the eighth edge. It also times every clock phase and counts chip-select low periods.

Each fault below shows up in a different measurement:
- An LSB-first or off-by-one shifter produces the wrong rebuilt bytes.
- A select line that changes too late marks the byte with the wrong type.
- A divider that is off by one, or one that reloads from the live input during a transfer, produces the wrong phase lengths.
- A chip select that rises between burst bytes shows up as more than one low period.

The stalled stream, the empty burst, the reserved type and a start pulse during a transfer are also covered:
- A design that takes a byte without a handshake, or that clocks during an empty request, consumes the wrong number of stream bytes or produces stray clock edges.
- A design that accepts the start pulse during a transfer produces a second transfer.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REQ_CMD      = 2'b00,
        REQ_CMD_DATA = 2'b01,
        REQ_BURST    = 2'b10,
        REQ_NONE     = 2'b11
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic csn;
        logic dc;
        logic sclk;
        logic sdo;
    } line_set_t;

    localparam line_set_t LINES_IDLE = '{csn: 1'b1, dc: 1'b1, sclk: 1'b1, sdo: 1'b1};

    // Line levels at the start of a byte: selected, clock low, first bit driven.
    function automatic line_set_t byte_start(input logic is_data, input logic first_bit);
        line_set_t l;
        l.csn  = 1'b0;
        l.dc   = is_data;
        l.sclk = 1'b0;
        l.sdo  = first_bit;
        return l;
    endfunction

endpackage

// File: rtl/sdw_halfper.sv
module sdw_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;

    assign expire = run && (cnt == ratio);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R4: the phase counter never runs beyond the captured ratio
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= ratio));
endmodule

// File: rtl/sdw_shifter.sv
module sdw_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb_next,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] bcnt;

    assign msb_next = sh[W-2];
    assign last     = (bcnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            bcnt <= '0;
        end else if (load) begin
            sh   <= load_val;
            bcnt <= '0;
        end else if (shift) begin
            sh   <= sh << 1;
            bcnt <= bcnt + 1'b1;
        end
    end

    // R2: no shift request once the final bit of a byte is on the line
    p_no_shift_past_last_r2: assert property (@(posedge clk) disable iff (rst)
        shift |-> !last);
    // R2: load and shift never collide
    p_load_shift_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));
endmodule

// File: rtl/serdisp_writer.sv
module serdisp_writer
    import sdw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        req_kind,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              busy,
    output logic              lcd_csn,
    output logic              lcd_dc,
    output logic              lcd_sclk,
    output logic              lcd_sdo
);
    seq_state_e        state;
    req_kind_e         kind_q;
    req_kind_e         kind_in;
    logic [DIV_W-1:0]  ratio_q;
    logic [LEN_W-1:0]  remain;
    line_set_t         lines_q;

    logic              run, expire, last, msb_next;
    logic              load_cmd, accept, load, shift;
    logic [BYTE_W-1:0] load_val;

    assign kind_in  = req_kind_e'(req_kind);
    assign in_ready = (state == ST_FETCH);
    assign busy     = (state != ST_IDLE);
    assign accept   = in_ready && in_valid;
    assign run      = (state == ST_LOW) || (state == ST_HIGH);
    assign load_cmd = (state == ST_IDLE) && start &&
                      ((kind_in == REQ_CMD) || (kind_in == REQ_CMD_DATA));
    assign load     = load_cmd || accept;
    assign load_val = load_cmd ? cmd_byte : in_data;
    assign shift    = (state == ST_HIGH) && expire && !last;

    assign lcd_csn  = lines_q.csn;
    assign lcd_dc   = lines_q.dc;
    assign lcd_sclk = lines_q.sclk;
    assign lcd_sdo  = lines_q.sdo;

    sdw_halfper #(.DIV_W(DIV_W)) u_halfper (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .ratio  (ratio_q),
        .expire (expire)
    );

    sdw_shifter #(.W(BYTE_W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .shift    (shift),
        .msb_next (msb_next),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind_q  <= REQ_CMD;
            ratio_q <= '0;
            remain  <= '0;
            lines_q <= LINES_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    lines_q <= LINES_IDLE;
                    if (start) begin
                        kind_q  <= kind_in;
                        ratio_q <= div_ratio;
                        case (kind_in)
                            REQ_CMD, REQ_CMD_DATA: begin
                                remain  <= (kind_in == REQ_CMD_DATA) ? LEN_W'(1) : '0;
                                lines_q <= byte_start(1'b0, cmd_byte[BYTE_W-1]);
                                state   <= ST_LOW;
                            end
                            REQ_BURST: begin
                                if (burst_len != '0) begin
                                    remain  <= burst_len;
                                    lines_q <= '{csn: 1'b0, dc: 1'b1, sclk: 1'b1, sdo: 1'b1};
                                    state   <= ST_FETCH;
                                end else begin
                                    state   <= ST_DONE;
                                end
                            end
                            default: state <= ST_DONE;
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (in_valid) begin
                        remain  <= remain - 1'b1;
                        lines_q <= byte_start(1'b1, in_data[BYTE_W-1]);
                        state   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (expire) begin
                        lines_q.sclk <= 1'b1;
                        state        <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (expire) begin
                        if (last) begin
                            if (remain != '0) begin
                                state <= ST_FETCH;
                            end else begin
                                lines_q <= LINES_IDLE;
                                state   <= ST_DONE;
                            end
                        end else begin
                            lines_q.sclk <= 1'b0;
                            lines_q.sdo  <= msb_next;
                            state        <= ST_LOW;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: lines idle whenever no request is running
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lcd_csn && lcd_dc && lcd_sclk && lcd_sdo && !in_ready));
    // R3: data held through a high clock phase while selected
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (lcd_sclk && $past(lcd_sclk) && !lcd_csn) |-> $stable(lcd_sdo));
    // R7: deselect happens with the clock high and busy still set
    p_end_order_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_csn) |-> (lcd_sclk && busy));
    // R9: a start during a request leaves the captured request unchanged
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(kind_q) && $stable(ratio_q)));
    // R10: stream is only offered readiness inside a selected transfer
    p_ready_in_xfer_r10: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (busy && !lcd_csn && lcd_sclk));
endmodule

// File: tb/serdisp_writer_bench.sv
module serdisp_writer_bench;
    localparam int DIV_W = 8;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       req_kind = 2'b00;
    logic [7:0]       cmd_byte = 8'h00;
    logic [LEN_W-1:0] burst_len = '0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic [7:0]       in_data = 8'h00;
    logic             in_valid = 1'b0;
    logic             in_ready, busy, lcd_csn, lcd_dc, lcd_sclk, lcd_sdo;

    always #2.5 clk = ~clk;

    serdisp_writer #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_serdisp_writer (
        .clk(clk), .rst(rst), .start(start), .req_kind(req_kind),
        .cmd_byte(cmd_byte), .burst_len(burst_len), .div_ratio(div_ratio),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .busy(busy), .lcd_csn(lcd_csn), .lcd_dc(lcd_dc),
        .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // stream source
    logic [7:0] src [0:15];
    int src_n = 0;
    int src_idx = 0;
    bit stall = 0;

    // decoded log
    logic [7:0] log_byte [0:63];
    logic       log_dc   [0:63];
    int log_n = 0;
    int exp_div = 0;
    int viol_timing = 0, viol_hold = 0, viol_csn = 0, viol_end = 0;
    int csn_lows = 0, busy_cycles = 0, edges = 0;

    logic prev_sclk = 1, prev_sdo = 1, prev_csn = 1, prev_busy = 0, prev_idle = 1;
    int low_run = 0, high_run = 0, bitc = 0;
    logic [7:0] shb = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_valid && in_ready) src_idx <= src_idx + 1;
    end

    always @(negedge clk) begin
        in_valid = (src_idx < src_n) && !(stall && (cyc % 4 != 0));
        in_data  = (src_idx < 16) ? src[src_idx] : 8'h00;
    end

    // line monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cycles++;
            if (!prev_sclk && lcd_sclk) begin
                edges++;
                if (lcd_csn) viol_csn++;
                if (low_run != exp_div + 1) viol_timing++;
                shb = {shb[6:0], lcd_sdo};
                if (bitc == 7) begin
                    if (log_n < 64) begin
                        log_byte[log_n] = shb;
                        log_dc[log_n]   = lcd_dc;
                    end
                    log_n++;
                    bitc = 0;
                end else bitc++;
                high_run = 1;
            end else if (prev_sclk && lcd_sclk) begin
                high_run++;
                if (lcd_sdo != prev_sdo && !lcd_csn && !prev_csn) viol_hold++;
            end else if (prev_sclk && !lcd_sclk) begin
                if (bitc != 0 && high_run != exp_div + 1) viol_timing++;
                low_run = 1;
            end else begin
                low_run++;
            end
            if (prev_csn && !lcd_csn) csn_lows++;
            if (prev_busy && !busy && !prev_idle) viol_end++;
        end
        prev_sclk = lcd_sclk;
        prev_sdo  = lcd_sdo;
        prev_csn  = lcd_csn;
        prev_busy = busy;
        prev_idle = lcd_csn && lcd_dc && lcd_sclk && lcd_sdo;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic clear_mon();
        log_n = 0; viol_timing = 0; viol_hold = 0; viol_csn = 0; viol_end = 0;
        csn_lows = 0; busy_cycles = 0; edges = 0; bitc = 0;
    endtask

    task automatic run_req(input logic [1:0] k, input logic [7:0] c,
                           input int len, input int dv);
        @(negedge clk);
        clear_mon();
        exp_div   = dv;
        req_kind  = k;
        cmd_byte  = c;
        burst_len = LEN_W'(len);
        div_ratio = DIV_W'(dv);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(lcd_csn && lcd_dc && lcd_sclk && lcd_sdo, req,
            {lcd_csn, lcd_dc, lcd_sclk, lcd_sdo}, 4'hF);
        chk(!busy && !in_ready, req, {busy, in_ready}, 0);
    endtask

    task automatic chk_common(input string tag);
        chk(viol_timing == 0, {tag, " R4 phase length"}, viol_timing, 0);
        chk(viol_hold == 0, {tag, " R3 data hold"}, viol_hold, 0);
        chk(viol_csn == 0, {tag, " R2 clock while deselected"}, viol_csn, 0);
        chk(viol_end == 0, {tag, " R7 idle before busy drop"}, viol_end, 0);
        chk_idle({tag, " R7 final idle"});
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk_idle("R1 reset state");
    endtask

    task automatic t_single_cmd(input logic [7:0] c, input int dv);
        run_req(2'b00, c, 0, dv);
        chk(log_n == 1, "R2 byte count", log_n, 1);
        chk(log_byte[0] == c, "R2 command byte", log_byte[0], c);
        chk(log_dc[0] == 1'b0, "R2 select low", log_dc[0], 0);
        chk(csn_lows == 1, "R2 one select period", csn_lows, 1);
        chk_common("R2");
    endtask

    task automatic t_cmd_data();
        src[0] = 8'hC3; src_n = 1; src_idx = 0; stall = 0;
        run_req(2'b01, 8'h3C, 0, 2);
        chk(log_n == 2, "R5 byte count", log_n, 2);
        chk(log_byte[0] == 8'h3C && log_dc[0] == 1'b0, "R5 command part",
            {log_dc[0], log_byte[0]}, 9'h03C);
        chk(log_byte[1] == 8'hC3 && log_dc[1] == 1'b1, "R5 data part",
            {log_dc[1], log_byte[1]}, 9'h1C3);
        chk(csn_lows == 1, "R5 select held", csn_lows, 1);
        chk_common("R5");
    endtask

    task automatic t_burst(input int n, input int dv, input bit st);
        for (int i = 0; i < 16; i++) src[i] = 8'(8'h11 * i + 8'h5A);
        src_n = n + 1; src_idx = 0; stall = st;
        run_req(2'b10, 8'hFF, n, dv);
        chk(log_n == n, "R6 burst byte count", log_n, n);
        for (int i = 0; i < n; i++) begin
            chk(log_byte[i] == src[i] && log_dc[i] == 1'b1, "R6 burst byte",
                {log_dc[i], log_byte[i]}, {1'b1, src[i]});
        end
        chk(csn_lows == 1, "R6 single select period", csn_lows, 1);
        chk(src_idx == n, "R10 bytes consumed", src_idx, n);
        chk_common("R6");
        src_n = 0; src_idx = 0; stall = 0;
    endtask

    task automatic t_empty(input logic [1:0] k, input string req);
        src[0] = 8'h99; src_n = 1; src_idx = 0;
        run_req(k, 8'hAA, 0, 1);
        chk(edges == 0, {req, " no clock"}, edges, 0);
        chk(csn_lows == 0, {req, " select untouched"}, csn_lows, 0);
        chk(busy_cycles == 1, {req, " busy one cycle"}, busy_cycles, 1);
        chk(src_idx == 0, {req, " stream untouched"}, src_idx, 0);
        chk_idle({req, " idle after"});
        src_n = 0; src_idx = 0;
    endtask

    task automatic t_ignore_start();
        @(negedge clk);
        clear_mon();
        exp_div = 1; req_kind = 2'b00; cmd_byte = 8'h81; div_ratio = 8'd1; start = 1;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        req_kind = 2'b00; cmd_byte = 8'h7E; div_ratio = 8'd0; start = 1;
        @(negedge clk);
        start = 0;
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(log_n == 1, "R9 no second transfer", log_n, 1);
        chk(log_byte[0] == 8'h81, "R9 original byte kept", log_byte[0], 8'h81);
        chk(viol_timing == 0, "R9 original timing kept", viol_timing, 0);
        chk_idle("R9 idle after");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_single_cmd(8'hA5, 0);
        t_single_cmd(8'h01, 3);
        t_cmd_data();
        t_burst(5, 1, 1'b0);
        t_burst(4, 0, 1'b1);
        t_burst(1, 3, 1'b0);
        t_empty(2'b10, "R8");
        t_empty(2'b11, "R11");
        t_ignore_start();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule